// File: doc/BRIEF.md
# Gen2 Speed-Change Stall Recovery Monitor

This block watches a running PCIe link for a speed change to Gen2 that has stopped making progress, and clears the stall by briefly forcing the PHY receiver on. On each periodic check trigger it samples a 64-bit debug vector, given as two 32-bit words. It reports whether the link is ready and, when the link is ready, decodes the training state from the lower word. If the training state is receiver-lock recovery, the block reads the PHY receive-valid flag through a register request/response port. A missing receive-valid together with that state counts as a stall.

On a stall the block raises a one-cycle event. It then forces the PHY receiver on through a read-modify-write of a receiver override register, which sets the data-enable and PLL-enable bits. It holds this for a programmable dwell of about 2 to 3 ms and then clears both bits with a second read-modify-write. A PHY access that gets no response within a bounded time abandons the sequence and returns the block to idle. Check triggers that arrive during a recovery are ignored.

Top module: `g2r_monitor`

## Requirements
- R1: After reset `link_up` is 0. One cycle after each `check_tick`, `link_up` equals the inverse of `dbg_hi[4]` (debug bit 36) as sampled with the tick. `link_up` only changes on a tick.
- R2: A tick starts a check only when `dbg_hi[4]` is 0 and `dbg_lo[5:0]` equals 6'h0D (receiver-lock recovery). The upper bits of `dbg_lo` are ignored. A check is a single read (`phy_we`=0) of PHY address 16'h100D. Any other tick issues no PHY access.
- R3: If bit 0 of the data returned for 16'h100D is 1 (receive valid), the check ends with no further PHY access and no `stall_evt`.
- R4: If that bit is 0, `stall_evt` is high for exactly one cycle. The block then reads 16'h1005 and writes to 16'h1005 the read value with bits 5 and 3 set (OR 16'h0028).
- R5: Between the response to the setting write and the next request, the block waits at least DWELL_CYCLES and at most DWELL_CYCLES+4 cycles, and it makes no PHY request during that wait.
- R6: After the dwell the block reads 16'h1005 again and writes back the newly read value with bits 5 and 3 cleared (AND ~16'h0028). Then it returns to idle.
- R7: A `check_tick` that arrives while a check or recovery is in progress starts no new check.
- R8: A request that gets no `phy_ack` is held for exactly ACK_TIMEOUT cycles and then withdrawn. The sequence is abandoned, with no further access, and the next qualifying tick starts a fresh check.
- R9: While `phy_req` is high and no ack has arrived, `phy_addr`, `phy_we` and `phy_wdata` stay constant. All writes go to 16'h1005 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_lo | input | DBG_W | Lower debug word; bits 5:0 hold the training state |
| dbg_hi | input | DBG_W | Upper debug word; bit 4 set means link not ready |
| check_tick | input | 1 | Periodic check trigger, one cycle |
| phy_req | output | 1 | PHY register access request, held until ack or timeout |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | ADDR_W | PHY register address |
| phy_wdata | output | DATA_W | Write data |
| phy_ack | input | 1 | One-cycle response to the pending request |
| phy_rdata | input | DATA_W | Read data, valid with `phy_ack` |
| link_up | output | 1 | Link ready, updated on each tick |
| stall_evt | output | 1 | One-cycle pulse per detected stall |

## Verification
The hardest situation to reach is an access that times out partway through a recovery: the stall has been flagged and the override read has completed, but the setting write never gets a response. The bench's PHY model can be told to withhold the ack for a chosen request index, counted from the start of the run. Pointing it at the third request of a stalled check drives the block into that state. The bench then confirms that no further request follows and that a later tick still starts a normal check. The dwell is checked in a similar way. The model returns a different override value before the clearing read, so the clearing write proves that the register was freshly read and not taken from the earlier one.

// File: rtl/g2r_pkg.sv
package g2r_pkg;

  localparam logic [15:0] RXV_REG_ADDR  = 16'h100D;
  localparam logic [15:0] OVR_REG_ADDR  = 16'h1005;
  localparam logic [15:0] OVR_FORCE_MSK = 16'h0028;  // bits 5 and 3
  localparam logic [5:0]  STALL_STATE   = 6'h0D;
  localparam int          LINK_NRDY_BIT = 4;          // in upper debug word

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_SET_RD,
    ST_SET_WR,
    ST_DWELL,
    ST_CLR_RD,
    ST_CLR_WR
  } rec_state_t;

endpackage

// File: rtl/g2r_link_sense.sv
module g2r_link_sense
  import g2r_pkg::*;
#(
  parameter int DBG_W  = 32,
  parameter int STATE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DBG_W-1:0] dbg_lo,
  input  logic [DBG_W-1:0] dbg_hi,
  input  logic             tick,
  output logic             link_up,
  output logic             chk_go
);

  logic               nrdy;
  logic [STATE_W-1:0] train_st;
  logic               unused_dbg;

  assign nrdy       = dbg_hi[LINK_NRDY_BIT];
  assign train_st   = dbg_lo[STATE_W-1:0];
  assign unused_dbg = ^{dbg_hi, dbg_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      link_up <= 1'b0;
      chk_go  <= 1'b0;
    end else begin
      chk_go <= 1'b0;
      if (tick) begin
        link_up <= ~nrdy;
        chk_go  <= ~nrdy && (train_st == STATE_W'(STALL_STATE));
      end
    end
  end

  // R1: link_up moves only on a tick
  a_r1_link_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(link_up));

endmodule

// File: rtl/g2r_access.sv
module g2r_access #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int ACK_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              done,
  output logic              tmo,
  output logic [DATA_W-1:0] rdata
);

  localparam int TW = (ACK_TIMEOUT > 2) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(ACK_TIMEOUT - 1);

  logic [TW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      wait_cnt  <= '0;
      done      <= 1'b0;
      tmo       <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      tmo  <= 1'b0;
      if (phy_req) begin
        if (phy_ack) begin
          phy_req <= 1'b0;
          done    <= 1'b1;
          rdata   <= phy_rdata;
        end else if (wait_cnt == T_LAST) begin
          phy_req <= 1'b0;
          tmo     <= 1'b1;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end else if (start) begin
        phy_req   <= 1'b1;
        phy_we    <= start_we;
        phy_addr  <= start_addr;
        phy_wdata <= start_wdata;
        wait_cnt  <= '0;
      end
    end
  end

  // R9: request fields hold while the request is pending
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ack) |=> (!phy_req ||
      ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))));

  // R8: completion and timeout never coincide
  a_r8_done_xor_tmo: assert property (@(posedge clk) disable iff (rst)
    !(done && tmo));

endmodule

// File: rtl/g2r_dwell_timer.sv
module g2r_dwell_timer #(
  parameter int DWELL_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic running,
  output logic expire
);

  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        cnt     <= CW'(DWELL_CYCLES - 1);
        running <= 1'b1;
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5: expiry is a single-cycle pulse
  a_r5_expire_pulse: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

endmodule

// File: rtl/g2r_monitor.sv
module g2r_monitor
  import g2r_pkg::*;
#(
  parameter int DBG_W        = 32,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int ACK_TIMEOUT  = 64,
  parameter int DWELL_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DBG_W-1:0]  dbg_lo,
  input  logic [DBG_W-1:0]  dbg_hi,
  input  logic              check_tick,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              link_up,
  output logic              stall_evt
);

  localparam logic [ADDR_W-1:0] A_RXV = ADDR_W'(RXV_REG_ADDR);
  localparam logic [ADDR_W-1:0] A_OVR = ADDR_W'(OVR_REG_ADDR);
  localparam logic [DATA_W-1:0] M_OVR = DATA_W'(OVR_FORCE_MSK);

  rec_state_t        state_q, state_d;
  logic              chk_go;
  logic              acc_start, acc_we, acc_done, acc_tmo;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, acc_rdata;
  logic              tmr_start, tmr_run, tmr_exp;
  logic              evt_set;

  g2r_link_sense #(.DBG_W(DBG_W), .STATE_W(6)) u_sense (
    .clk(clk), .rst(rst), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
    .tick(check_tick), .link_up(link_up), .chk_go(chk_go)
  );

  g2r_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_TIMEOUT(ACK_TIMEOUT)) u_acc (
    .clk(clk), .rst(rst),
    .start(acc_start), .start_we(acc_we), .start_addr(acc_addr),
    .start_wdata(acc_wdata),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
    .done(acc_done), .tmo(acc_tmo), .rdata(acc_rdata)
  );

  g2r_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .running(tmr_run), .expire(tmr_exp)
  );

  always_comb begin
    state_d   = state_q;
    acc_start = 1'b0;
    acc_we    = 1'b0;
    acc_addr  = A_OVR;
    acc_wdata = acc_rdata;
    tmr_start = 1'b0;
    evt_set   = 1'b0;
    if (acc_tmo) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (chk_go) begin
          acc_start = 1'b1;
          acc_addr  = A_RXV;
          state_d   = ST_CHK;
        end
        ST_CHK: if (acc_done) begin
          if (acc_rdata[0]) begin
            state_d = ST_IDLE;
          end else begin
            evt_set   = 1'b1;
            acc_start = 1'b1;
            state_d   = ST_SET_RD;
          end
        end
        ST_SET_RD: if (acc_done) begin
          acc_start = 1'b1;
          acc_we    = 1'b1;
          acc_wdata = acc_rdata | M_OVR;
          state_d   = ST_SET_WR;
        end
        ST_SET_WR: if (acc_done) begin
          tmr_start = 1'b1;
          state_d   = ST_DWELL;
        end
        ST_DWELL: if (tmr_exp) begin
          acc_start = 1'b1;
          state_d   = ST_CLR_RD;
        end
        ST_CLR_RD: if (acc_done) begin
          acc_start = 1'b1;
          acc_we    = 1'b1;
          acc_wdata = acc_rdata & ~M_OVR;
          state_d   = ST_CLR_WR;
        end
        ST_CLR_WR: if (acc_done) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      stall_evt <= 1'b0;
    end else begin
      state_q   <= state_d;
      stall_evt <= evt_set;
    end
  end

  // R4: stall event lasts one cycle
  a_r4_evt_pulse: assert property (@(posedge clk) disable iff (rst)
    stall_evt |=> !stall_evt);

  // R9: every write targets the override register
  a_r9_write_target: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_we) |-> (phy_addr == A_OVR));

  // R5: the PHY port is quiet while the dwell timer runs
  a_r5_quiet_dwell: assert property (@(posedge clk) disable iff (rst)
    tmr_run |-> !phy_req);

  // R8: a timed-out access returns the sequencer to idle
  a_r8_tmo_idle: assert property (@(posedge clk) disable iff (rst)
    acc_tmo |=> (state_q == ST_IDLE));

endmodule

// File: tb/g2r_monitor_tb_top.sv
module g2r_monitor_tb_top;

  localparam int DWELL = 100;
  localparam int TMO   = 16;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_lo = '0, dbg_hi = '0;
  logic        check_tick = 1'b0;
  logic        phy_req, phy_we, phy_ack;
  logic [15:0] phy_addr, phy_wdata, phy_rdata;
  logic        link_up, stall_evt;

  always #2 clk = ~clk;

  g2r_monitor #(.ACK_TIMEOUT(TMO), .DWELL_CYCLES(DWELL)) dut_i (
    .clk(clk), .rst(rst), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
    .check_tick(check_tick), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata), .link_up(link_up), .stall_evt(stall_evt)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // PHY model controls
  int          mute_idx = -1;
  logic [15:0] rxv_val = 16'h0001;
  logic [15:0] ovr_val = 16'h0000;

  // logs
  int          cyc = 0;
  int          n_log = 0, n_start = 0;
  logic [15:0] lg_addr [64];
  logic        lg_we   [64];
  logic [15:0] lg_wdata[64];
  int          lg_ack  [64];
  int          st_cyc  [64];
  int          lat_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      phy_ack <= 1'b0; phy_rdata <= '0; lat_cnt <= 0;
    end else if (phy_req && phy_ack) begin
      lg_addr[n_log]  <= phy_addr;
      lg_we[n_log]    <= phy_we;
      lg_wdata[n_log] <= phy_wdata;
      lg_ack[n_log]   <= cyc + 1;
      n_log   <= n_log + 1;
      phy_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (phy_req && (n_start - 1 != mute_idx)) begin
      if (lat_cnt == LAT - 1) begin
        phy_ack   <= 1'b1;
        phy_rdata <= (phy_addr == 16'h100D) ? rxv_val :
                     (phy_addr == 16'h1005) ? ovr_val : 16'h0000;
      end
      lat_cnt <= lat_cnt + 1;
    end else begin
      phy_ack <= 1'b0;
      lat_cnt <= 0;
    end
  end

  // monitor away from the edge
  logic        req_q = 0, stall_q = 0;
  logic [33:0] held;
  int          cur_run = 0, last_run = 0, hold_err = 0;
  int          stall_cnt = 0, stall_hi = 0;

  always @(negedge clk) begin
    if (phy_req && !req_q) begin
      st_cyc[n_start] = cyc;
      n_start = n_start + 1;
      held = {phy_we, phy_addr, phy_wdata};
    end else if (phy_req && held != {phy_we, phy_addr, phy_wdata}) begin
      hold_err = hold_err + 1;
    end
    if (phy_req) cur_run = cur_run + 1;
    else if (cur_run > 0) begin last_run = cur_run; cur_run = 0; end
    if (stall_evt) stall_hi = stall_hi + 1;
    if (stall_evt && !stall_q) stall_cnt = stall_cnt + 1;
    req_q   = phy_req;
    stall_q = stall_evt;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    dbg_hi = hi; dbg_lo = lo; check_tick = 1'b1;
    @(negedge clk);
    check_tick = 1'b0;
  endtask

  task automatic t_reset;
    chk(link_up == 1'b0, "R1 reset link_up", link_up, 0);
    chk(stall_evt == 1'b0, "R4 reset stall_evt", stall_evt, 0);
    chk(phy_req == 1'b0, "R2 reset phy_req", phy_req, 0);
  endtask

  task automatic t_link_down;
    int base = n_start;
    do_tick(32'h0000_0010, 32'h0000_000D);
    wait_cyc(10);
    chk(link_up == 1'b0, "R1 link not ready", link_up, 0);
    chk(n_start == base, "R2 no access when not ready", n_start, base);
  endtask

  task automatic t_link_up_other;
    int base = n_start;
    do_tick(32'hFFFF_FFEF, 32'h0000_0011);
    wait_cyc(10);
    chk(link_up == 1'b1, "R1 link ready", link_up, 1);
    chk(n_start == base, "R2 no access other state", n_start, base);
  endtask

  task automatic t_rx_valid;
    int base = n_log;
    int sc = stall_cnt;
    rxv_val = 16'hFFFF;
    do_tick(32'h0, 32'hFFFF_FFCD);
    wait_cyc(20);
    chk(n_log == base + 1, "R2 single check access", n_log - base, 1);
    chk(lg_addr[base] == 16'h100D && !lg_we[base], "R2 check reads 100D",
        lg_addr[base], 16'h100D);
    chk(stall_cnt == sc, "R3 no stall on rx valid", stall_cnt - sc, 0);
  endtask

  task automatic t_stall;
    int base = n_log;
    int sb = n_start;
    int sc = stall_cnt;
    int sh = stall_hi;
    int gap;
    rxv_val = 16'hFFFE;
    ovr_val = 16'h1234;
    do_tick(32'h0, 32'h0000_000D);
    wait_cyc(30);
    chk(stall_cnt == sc + 1, "R4 one stall event", stall_cnt - sc, 1);
    chk(stall_hi == sh + 1, "R4 stall pulse width", stall_hi - sh, 1);
    chk(n_log == base + 3, "R4 set phase accesses", n_log - base, 3);
    chk(lg_addr[base+1] == 16'h1005 && !lg_we[base+1], "R4 set read 1005",
        lg_addr[base+1], 16'h1005);
    chk(lg_we[base+2] && lg_wdata[base+2] == 16'h123C, "R4 set write data",
        lg_wdata[base+2], 16'h123C);
    ovr_val = 16'h00FF;
    do_tick(32'h0, 32'h0000_000D);  // R7: during dwell
    wait_cyc(10);
    chk(n_start == sb + 3, "R7 tick ignored during dwell", n_start - sb, 3);
    wait_cyc(DWELL + 30);
    chk(n_log == base + 5, "R6 total accesses", n_log - base, 5);
    gap = st_cyc[sb+3] - lg_ack[base+2];
    chk(gap >= DWELL && gap <= DWELL + 4, "R5 dwell length", gap, DWELL);
    chk(lg_addr[base+3] == 16'h1005 && !lg_we[base+3], "R6 clear re-read",
        lg_addr[base+3], 16'h1005);
    chk(lg_we[base+4] && lg_wdata[base+4] == 16'h00D7, "R6 clear write data",
        lg_wdata[base+4], 16'h00D7);
    chk(stall_cnt == sc + 1, "R7 no extra stall", stall_cnt - sc, 1);
  endtask

  task automatic t_timeout_idle;
    int base = n_log;
    int sc = stall_cnt;
    rxv_val = 16'h0000;
    mute_idx = n_start;
    do_tick(32'h0, 32'h0000_000D);
    wait_cyc(TMO + 20);
    chk(last_run == TMO, "R8 request held for timeout", last_run, TMO);
    chk(phy_req == 1'b0, "R8 request withdrawn", phy_req, 0);
    chk(n_log == base, "R8 no completed access", n_log - base, 0);
    chk(stall_cnt == sc, "R8 no stall after timeout", stall_cnt - sc, 0);
    mute_idx = -1;
    rxv_val = 16'h0001;
    do_tick(32'h0, 32'h0000_000D);
    wait_cyc(20);
    chk(n_log == base + 1, "R8 fresh check after timeout", n_log - base, 1);
  endtask

  task automatic t_abort;
    int base = n_log;
    int sb = n_start;
    int sc = stall_cnt;
    rxv_val = 16'h0000;
    ovr_val = 16'h0000;
    mute_idx = n_start + 2;
    do_tick(32'h0, 32'h0000_000D);
    wait_cyc(TMO + DWELL + 60);
    chk(n_log == base + 2, "R8 abandon mid recovery", n_log - base, 2);
    chk(n_start == sb + 3, "R8 no access after abandon", n_start - sb, 3);
    chk(stall_cnt == sc + 1, "R4 stall before abandon", stall_cnt - sc, 1);
    mute_idx = -1;
    rxv_val = 16'h0001;
    do_tick(32'h0, 32'h0000_000D);
    wait_cyc(20);
    chk(n_log == base + 3, "R8 check after abandon", n_log - base, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_link_down();
    t_link_up_other();
    t_link_down();
    t_rx_valid();
    t_stall();
    t_timeout_idle();
    t_abort();
    chk(hold_err == 0, "R9 request fields stable", hold_err, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule